// File: doc/BRIEF.md
# Clock Watchdog with Safe-Frequency Fallback

This block guards the frequency-select path of a programmable clock generator. Once armed, it counts down a programmable number of time units. If software does not service it before the count runs out, it raises a sticky alarm and emits a one-cycle alarm-reset pulse. It also replaces the normal 5-bit frequency select with a safe code. The safe code comes either from strap pins captured just after reset or from a programmed 5-bit field. Both use the same encoding as the normal frequency select.

A timebase tick input stands in for real time. An internal prescaler turns every `UNIT_DIV` ticks into one time unit, and the timeout is the count field times that unit. The enable comes from a strap pin captured after reset until software first writes the enable field. From then on the written value governs.

The control state machine has three states:
- **IDLE**: disabled.
- **COUNT**: armed and counting.
- **TRIPPED**: alarm raised.

Its transitions are:
- **IDLE→COUNT** (arm): taken when the effective enable is 1. The counter is loaded and the unit phase restarts.
- **COUNT→COUNT** (service): on a service strobe, the counter is reloaded and the unit phase restarts.
- **COUNT→COUNT** (decrement): on a unit pulse while the counter is above 1.
- **COUNT→TRIPPED** (expire): on a unit pulse while the counter is 1 or 0.
- **COUNT→IDLE** (disarm): taken when the enable drops.
- **TRIPPED→COUNT** (clear, rearm): on an alarm clear while enabled.
- **TRIPPED→IDLE** (clear, stop): on an alarm clear while disabled.

Top module: `clk_watchdog`

## Requirements
- R1: After reset the alarm and the alarm-reset pulse are 0 and `fs_o` equals `norm_fs_i`. The count field resets to 8, so enabling with no count write expires after 8 units. The enable field, the safe-code field and the source select all reset to 0.
- R2: The strap enable and strap frequency pins are captured on the first clock edge after reset is released. Later changes on those pins have no effect.
- R3: Until the enable field is first written, the captured strap enable decides whether the watchdog runs. After a write, the written value (1 = run, 0 = stop) replaces the strap.
- R4: After arming or servicing, expiry occurs on exactly the N-th unit pulse, where N is the count field. A count of 0 expires on the first unit pulse. One unit pulse is produced for every `UNIT_DIV` pulses on `tick_i`.
- R5: A service strobe reloads the count and restarts the unit phase. A service strobe in the same cycle as the expiring tick wins, and no alarm is raised.
- R6: On expiry, `alarm_o` and `alarm_rst_o` go to 1 after the same clock edge. `alarm_rst_o` lasts exactly one cycle.
- R7: While the alarm is set, `fs_o` carries the safe code and ignores `norm_fs_i`. Source select 0 takes the captured strap frequency; source select 1 takes the 5-bit safe-code field.
- R8: The alarm stays set until `alarm_clr_i` is pulsed, and service strobes do not clear it. After a clear while enabled, a full new count starts.
- R9: Dropping the enable while counting stops the count, so no alarm follows. Dropping the enable while the alarm is set does not clear the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Hardware enable strap, captured after reset |
| strap_fs_i | input | 5 | Strap frequency code, captured after reset |
| tick_i | input | 1 | Timebase tick, one cycle per pulse |
| kick_i | input | 1 | Service strobe |
| alarm_clr_i | input | 1 | Software alarm clear strobe |
| cnt_we_i | input | 1 | Count field write strobe |
| cnt_wd_i | input | 8 | Count field write data |
| en_we_i | input | 1 | Enable field write strobe |
| en_wd_i | input | 1 | Enable field write data |
| sf_we_i | input | 1 | Safe-code field write strobe |
| sf_wd_i | input | 5 | Safe-code field write data |
| src_we_i | input | 1 | Safe-source select write strobe |
| src_wd_i | input | 1 | Safe-source select data (0 strap, 1 field) |
| norm_fs_i | input | 5 | Normal frequency select |
| alarm_o | output | 1 | Sticky alarm status |
| alarm_rst_o | output | 1 | One-cycle pulse on expiry |
| fs_o | output | 5 | Effective frequency select |

## Verification
A service strobe and the tick that would end the count can arrive in the same cycle. The bench drives `kick_i` together with the final unit's tick, after exactly N×UNIT_DIV−1 plain ticks. It then expects no alarm, followed by a full fresh window before expiry. A clear and a disable can also coincide with a held alarm. The bench drops the enable while the alarm is set and checks that the alarm remains until it is explicitly cleared.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    localparam int FS_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_TRIPPED = 2'd2
    } wd_state_e;
endpackage

// File: rtl/cwd_prescale.sv
module cwd_prescale #(
    parameter int UNIT_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic restart_i,
    output logic unit_o
);
    generate
        if (UNIT_DIV <= 1) begin : g_pass
            assign unit_o = tick_i;
        end else begin : g_div
            localparam int PW = $clog2(UNIT_DIV);
            localparam logic [PW-1:0] LAST = PW'(UNIT_DIV - 1);
            logic [PW-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (restart_i) begin
                    phase_q <= '0;
                end else if (tick_i) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
                end
            end

            assign unit_o = tick_i && (phase_q == LAST) && !restart_i;
        end
    endgenerate
endmodule

// File: rtl/cwd_regs.sv
module cwd_regs #(
    parameter int CNT_W     = 8,
    parameter int CNT_RESET = 8,
    parameter int FS_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_en_i,
    input  logic [FS_W-1:0]  strap_fs_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wd_i,
    input  logic             en_we_i,
    input  logic             en_wd_i,
    input  logic             sf_we_i,
    input  logic [FS_W-1:0]  sf_wd_i,
    input  logic             src_we_i,
    input  logic             src_wd_i,
    output logic [CNT_W-1:0] load_cnt_o,
    output logic             eff_en_o,
    output logic [FS_W-1:0]  safe_code_o
);
    logic             captured_q;
    logic             strap_en_q;
    logic [FS_W-1:0]  strap_fs_q;
    logic             ovr_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic [FS_W-1:0]  sf_q;
    logic             src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            captured_q <= 1'b0;
            strap_en_q <= 1'b0;
            strap_fs_q <= '0;
        end else if (!captured_q) begin
            captured_q <= 1'b1;
            strap_en_q <= strap_en_i;
            strap_fs_q <= strap_fs_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            en_q  <= 1'b0;
            cnt_q <= CNT_W'(CNT_RESET);
            sf_q  <= '0;
            src_q <= 1'b0;
        end else begin
            if (en_we_i) begin
                ovr_q <= 1'b1;
                en_q  <= en_wd_i;
            end
            if (cnt_we_i) cnt_q <= cnt_wd_i;
            if (sf_we_i)  sf_q  <= sf_wd_i;
            if (src_we_i) src_q <= src_wd_i;
        end
    end

    assign load_cnt_o  = cnt_q;
    assign eff_en_o    = ovr_q ? en_q : (captured_q & strap_en_q);
    assign safe_code_o = src_q ? sf_q : strap_fs_q;
endmodule

// File: rtl/cwd_fsm.sv
module cwd_fsm
    import cwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             kick_i,
    input  logic             clr_i,
    input  logic             unit_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             reload_o,
    output logic             alarm_o,
    output logic             pulse_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pulse_q, pulse_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pulse_q <= pulse_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        pulse_d  = 1'b0;
        reload_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) begin
                    state_d  = ST_COUNT;
                    cnt_d    = load_i;
                    reload_o = 1'b1;
                end
            end
            ST_COUNT: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                end else if (kick_i) begin
                    cnt_d    = load_i;
                    reload_o = 1'b1;
                end else if (unit_i) begin
                    if (cnt_q <= ONE) begin
                        state_d = ST_TRIPPED;
                        pulse_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            ST_TRIPPED: begin
                if (clr_i) begin
                    if (en_i) begin
                        state_d  = ST_COUNT;
                        cnt_d    = load_i;
                        reload_o = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        alarm_o = (state_q == ST_TRIPPED);
        pulse_o = pulse_q;
    end
endmodule

// File: rtl/cwd_fs_mux.sv
module cwd_fs_mux #(
    parameter int FS_W = 5
) (
    input  logic            alarm_i,
    input  logic [FS_W-1:0] safe_i,
    input  logic [FS_W-1:0] norm_i,
    output logic [FS_W-1:0] fs_o
);
    assign fs_o = alarm_i ? safe_i : norm_i;
endmodule

// File: rtl/clk_watchdog.sv
module clk_watchdog #(
    parameter int UNIT_DIV  = 1000,
    parameter int CNT_W     = 8,
    parameter int CNT_RESET = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      strap_en_i,
    input  logic [cwd_pkg::FS_W-1:0]  strap_fs_i,
    input  logic                      tick_i,
    input  logic                      kick_i,
    input  logic                      alarm_clr_i,
    input  logic                      cnt_we_i,
    input  logic [CNT_W-1:0]          cnt_wd_i,
    input  logic                      en_we_i,
    input  logic                      en_wd_i,
    input  logic                      sf_we_i,
    input  logic [cwd_pkg::FS_W-1:0]  sf_wd_i,
    input  logic                      src_we_i,
    input  logic                      src_wd_i,
    input  logic [cwd_pkg::FS_W-1:0]  norm_fs_i,
    output logic                      alarm_o,
    output logic                      alarm_rst_o,
    output logic [cwd_pkg::FS_W-1:0]  fs_o
);
    localparam int FW = cwd_pkg::FS_W;

    logic [CNT_W-1:0] load_cnt;
    logic             eff_en;
    logic [FW-1:0]    safe_code;
    logic             reload;
    logic             unit;

    cwd_regs #(.CNT_W(CNT_W), .CNT_RESET(CNT_RESET), .FS_W(FW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .strap_en_i(strap_en_i), .strap_fs_i(strap_fs_i),
        .cnt_we_i(cnt_we_i), .cnt_wd_i(cnt_wd_i),
        .en_we_i(en_we_i), .en_wd_i(en_wd_i),
        .sf_we_i(sf_we_i), .sf_wd_i(sf_wd_i),
        .src_we_i(src_we_i), .src_wd_i(src_wd_i),
        .load_cnt_o(load_cnt), .eff_en_o(eff_en), .safe_code_o(safe_code)
    );

    cwd_prescale #(.UNIT_DIV(UNIT_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .restart_i(reload), .unit_o(unit)
    );

    cwd_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_i(eff_en), .kick_i(kick_i),
        .clr_i(alarm_clr_i), .unit_i(unit), .load_i(load_cnt),
        .reload_o(reload), .alarm_o(alarm_o), .pulse_o(alarm_rst_o)
    );

    cwd_fs_mux #(.FS_W(FW)) u_mux (
        .alarm_i(alarm_o), .safe_i(safe_code), .norm_i(norm_fs_i), .fs_o(fs_o)
    );
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       kick_i,
    input logic       alarm_clr_i,
    input logic       sf_we_i,
    input logic       src_we_i,
    input logic       alarm_o,
    input logic       alarm_rst_o,
    input logic [4:0] fs_o
);
    a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_rst_o |=> !alarm_rst_o);

    a_r6_pulse_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> alarm_rst_o);

    a_r4_expiry_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_o) |-> $past(tick_i));

    a_r5_service_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_i && !alarm_o) |=> !alarm_rst_o);

    a_r8_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !alarm_clr_i) |=> alarm_o);

    a_r7_safe_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && $past(alarm_o) && !$past(sf_we_i) && !$past(src_we_i))
            |-> $stable(fs_o));
endmodule

bind clk_watchdog cwd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .kick_i(kick_i),
    .alarm_clr_i(alarm_clr_i), .sf_we_i(sf_we_i), .src_we_i(src_we_i),
    .alarm_o(alarm_o), .alarm_rst_o(alarm_rst_o), .fs_o(fs_o)
);

// File: tb/clk_watchdog_tb_top.sv
module clk_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int NVEC       = 5;
    localparam logic [7:0] VEC_CNT [NVEC] = '{8'd1, 8'd3, 8'd0, 8'd2, 8'd6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_en = 1'b0;
    logic [4:0] strap_fs = 5'h13;
    logic       tick = 1'b0, kick = 1'b0, clr = 1'b0;
    logic       cnt_we = 1'b0, en_we = 1'b0, en_wd = 1'b0;
    logic       sf_we = 1'b0, src_we = 1'b0, src_wd = 1'b0;
    logic [7:0] cnt_wd = '0;
    logic [4:0] sf_wd = '0;
    logic [4:0] norm_fs = 5'h04;
    logic       alarm, arst;
    logic [4:0] fs;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_watchdog #(.UNIT_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_en_i(strap_en), .strap_fs_i(strap_fs),
        .tick_i(tick), .kick_i(kick), .alarm_clr_i(clr),
        .cnt_we_i(cnt_we), .cnt_wd_i(cnt_wd), .en_we_i(en_we), .en_wd_i(en_wd),
        .sf_we_i(sf_we), .sf_wd_i(sf_wd), .src_we_i(src_we), .src_wd_i(src_wd),
        .norm_fs_i(norm_fs), .alarm_o(alarm), .alarm_rst_o(arst), .fs_o(fs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic strobe_kick(input bit with_tick);
        @(negedge clk) begin kick = 1'b1; tick = with_tick; end
        @(negedge clk) begin kick = 1'b0; tick = 1'b0; end
    endtask

    task automatic strobe_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        @(negedge clk) begin cnt_we = 1'b1; cnt_wd = v; end
        @(negedge clk) cnt_we = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        @(negedge clk) begin en_we = 1'b1; en_wd = v; end
        @(negedge clk) en_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state; straps en=0 fs=0x13 are captured
        do_reset();
        chk("R1 alarm", alarm, 0);
        chk("R1 pulse", arst, 0);
        chk("R1 fs normal", fs, 5'h04);
        // R2: change straps after capture -> no effect
        strap_en = 1'b1; strap_fs = 5'h0a;
        ticks(40);
        chk("R2 late strap enable ignored", alarm, 0);
        // R3 software enable overrides strap; R1 default count 8
        wr_en(1'b1);
        ticks(8*DIV - 1);
        chk("R1 default count not yet", alarm, 0);
        ticks(1);
        chk("R1 R4 default count expiry", alarm, 1);
        chk("R6 pulse with alarm", arst, 1);
        chk("R7 strap code captured", fs, 5'h13);
        @(negedge clk);
        chk("R6 pulse one cycle", arst, 0);
        // R8 service does not clear
        strobe_kick(1'b0);
        ticks(3);
        chk("R8 kick ignored in alarm", alarm, 1);
        // R7 programmed source, normal ignored
        @(negedge clk) begin sf_we = 1'b1; sf_wd = 5'h1b; src_we = 1'b1; src_wd = 1'b1; end
        @(negedge clk) begin sf_we = 1'b0; src_we = 1'b0; end
        chk("R7 field source", fs, 5'h1b);
        norm_fs = 5'h11;
        @(negedge clk);
        chk("R7 normal ignored in alarm", fs, 5'h1b);
        strobe_clr();
        chk("R8 clear", alarm, 0);
        chk("R8 fs back to normal", fs, 5'h11);

        // Table walk: R4 count windows
        for (int v = 0; v < NVEC; v++) begin
            int units;
            units = (VEC_CNT[v] == 0) ? 1 : int'(VEC_CNT[v]);
            wr_cnt(VEC_CNT[v]);
            strobe_kick(1'b0);
            ticks(units*DIV - 1);
            chk($sformatf("R4 vec%0d early", v), alarm, 0);
            ticks(1);
            chk($sformatf("R4 vec%0d expiry", v), alarm, 1);
            strobe_clr();
        end

        // R5 service coincident with final tick
        wr_cnt(8'd2);
        strobe_kick(1'b0);
        ticks(2*DIV - 1);
        strobe_kick(1'b1);
        chk("R5 service wins", alarm, 0);
        ticks(2*DIV - 1);
        chk("R5 fresh window early", alarm, 0);
        ticks(1);
        chk("R5 fresh window expiry", alarm, 1);
        strobe_clr();

        // R9 disable mid-count
        strobe_kick(1'b0);
        ticks(DIV);
        wr_en(1'b0);
        ticks(20);
        chk("R9 disabled no alarm", alarm, 0);
        // R9 alarm survives disable
        wr_en(1'b1);
        ticks(2*DIV);
        chk("R9 alarm raised", alarm, 1);
        wr_en(1'b0);
        chk("R9 alarm survives disable", alarm, 1);
        strobe_clr();
        ticks(3*DIV);
        chk("R9 off after clear", alarm, 0);

        // R2 strap enable captured at 1, later pins ignored
        strap_en = 1'b1; strap_fs = 5'h07;
        do_reset();
        strap_en = 1'b0; strap_fs = 5'h1f;
        ticks(8*DIV);
        chk("R2 R3 strap enable runs", alarm, 1);
        chk("R2 captured strap code", fs, 5'h07);

        finish_run();
    end
endmodule